// File: doc/BRIEF.md
# DMA Channel Bus Arbiter

This block chooses the owner of an internal bus for one transfer unit at a time. The candidates are a set of DMA channels and the CPU. Each channel presents a request line that stays high while it still has units left to move. Each channel also has a mode bit that marks it as a burst channel or a cycle-steal channel. A global select picks fixed priority or rotating (round-robin) priority. A single strobe, `unit_done`, marks the end of the unit on the bus. The next owner is registered only at that strobe, so the grants stay steady for the whole unit.

Burst channels keep the CPU off the bus until none of them has work left. A cycle-steal channel that outranks the active burst channel interleaves with it one unit at a time, and the CPU gets no slot in between. A cycle-steal channel that runs alone alternates its units with CPU cycles. Under round-robin, a channel that has just been served drops to the lowest rank. If round-robin is selected while burst and cycle-steal requesters are both present, the block raises an error flag. In that case it keeps the rotation but does not lock the CPU out.

Top module: `dma_bus_arbiter`

## Requirements
- R1: While `rst` is high and after it is released, `cpu_grant` is 1, `ch_grant` is all zero and `mix_err` is 0. The rotation starts with channel 0 ranked highest.
- R2: The grant outputs change only on a clock edge where `unit_done` is 1. `{cpu_grant, ch_grant}` always has exactly one bit set.
- R3: With `rr_mode`=0 (fixed priority), a lower channel index ranks higher. A higher-ranked burst requester (`ch_is_burst`=1) takes the bus at the next boundary, even from a lower channel that is mid-burst. It keeps the bus until its request drops, and then the interrupted burst channel resumes.
- R4: With fixed priority, a cycle-steal requester (`ch_is_burst`=0) that outranks the highest burst requester takes the bus first. The two then alternate one unit each (steal, burst, steal, ...) and the CPU gets no slot.
- R5: At a boundary where any burst channel is requesting, the CPU is not granted. This does not apply when round-robin is on and a cycle-steal requester is also present.
- R6: With fixed priority, when several burst channels request together, the one with the lowest index is granted.
- R7: When only cycle-steal channels request and no burst channel does, units alternate between the highest-ranked requester and the CPU. A channel is granted first when the CPU owned the previous unit.
- R8: At a boundary with no request pending, the CPU is granted.
- R9: With `rr_mode`=1, the requester ranked first from the rotation pointer is chosen. After channel n is granted, channel n+1 (modulo the channel count) ranks highest. The pointer moves only under round-robin. When only burst channels request, there are no CPU slots.
- R10: `mix_err` is 1 one cycle after `rr_mode`=1 with at least one burst and one cycle-steal requester present, and 0 one cycle after that condition ends.
- R11: With `rr_mode`=1 and any cycle-steal requester present (including the mixed case of R10), channel units alternate with CPU units in rotation order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rr_mode | input | 1 | 1 = round-robin priority, 0 = fixed priority |
| unit_done | input | 1 | End of the current transfer unit; the next owner is registered |
| ch_req | input | NCH | Per-channel request, high while units remain |
| ch_is_burst | input | NCH | Per-channel mode: 1 = burst, 0 = cycle-steal |
| ch_grant | output | NCH | One-hot channel grant |
| cpu_grant | output | 1 | CPU owns the bus |
| mix_err | output | 1 | Round-robin selected with mixed burst and cycle-steal requesters |

## Verification
Preemption and interleaving can both act at the same boundary. This happens when a higher-ranked cycle-steal request appears at the point where a burst channel would simply keep the bus. The bench raises a channel 0 cycle-steal request while channel 1 is bursting. It then expects channel 0 at the very next boundary and strict alternation after that, with no CPU slot. In round-robin, rotation and the error flag meet in the mixed case. The bench expects the flag one cycle after the mix appears, while the grants still follow the rotated order with CPU slots.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    // Kind of owner registered for the current unit
    typedef enum logic [1:0] {
        OWN_CPU   = 2'd0,
        OWN_BURST = 2'd1,
        OWN_STEAL = 2'd2
    } owner_kind_e;

    // Wrap an index to the next slot of an n-entry ring
    function automatic int ring_next(input int v, input int n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/arb_mode_split.sv
module arb_mode_split #(
    parameter int NCH = 4
) (
    input  logic           rr_mode,
    input  logic [NCH-1:0] ch_req,
    input  logic [NCH-1:0] ch_is_burst,
    output logic [NCH-1:0] burst_req,
    output logic [NCH-1:0] steal_req,
    output logic           any_burst,
    output logic           any_steal,
    output logic           mix_now
);
    assign burst_req = ch_req & ch_is_burst;
    assign steal_req = ch_req & ~ch_is_burst;
    assign any_burst = |burst_req;
    assign any_steal = |steal_req;
    assign mix_now   = rr_mode & any_burst & any_steal;
endmodule

// File: rtl/arb_ring_pick.sv
module arb_ring_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    input  logic [IW-1:0] start,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(start) + k;
            if (j >= N) j = j - N;
            if (!found && vec[j]) begin
                found = 1'b1;
                idx   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/arb_owner_core.sv
module arb_owner_core
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4,
    parameter int IW  = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rr_mode,
    input  logic           unit_done,
    input  logic [NCH-1:0] ch_is_burst,
    input  logic           any_burst,
    input  logic           any_steal,
    input  logic           mix_now,
    input  logic           b_found,
    input  logic [IW-1:0]  b_idx,
    input  logic           s_found,
    input  logic [IW-1:0]  s_idx,
    input  logic           a_found,
    input  logic [IW-1:0]  a_idx,
    output logic [IW-1:0]  ptr_q,
    output logic [NCH-1:0] grant_q,
    output logic           cpu_q,
    output logic           mix_q
);
    owner_kind_e     kind_q, nxt_kind;
    logic            nxt_cpu;
    logic [IW-1:0]   nxt_idx;
    logic [NCH-1:0]  nxt_vec;

    always_comb begin
        nxt_cpu  = 1'b1;
        nxt_idx  = '0;
        nxt_kind = OWN_CPU;
        if (!rr_mode) begin
            if (b_found) begin
                nxt_cpu = 1'b0;
                if (s_found && (s_idx < b_idx) && (kind_q != OWN_STEAL)) begin
                    nxt_idx  = s_idx;
                    nxt_kind = OWN_STEAL;
                end else begin
                    nxt_idx  = b_idx;
                    nxt_kind = OWN_BURST;
                end
            end else if (s_found && (kind_q == OWN_CPU)) begin
                nxt_cpu  = 1'b0;
                nxt_idx  = s_idx;
                nxt_kind = OWN_STEAL;
            end
        end else if (a_found) begin
            if ((b_found && !s_found) || (kind_q == OWN_CPU)) begin
                nxt_cpu  = 1'b0;
                nxt_idx  = a_idx;
                nxt_kind = ch_is_burst[a_idx] ? OWN_BURST : OWN_STEAL;
            end
        end
    end

    always_comb begin
        nxt_vec = '0;
        if (!nxt_cpu) nxt_vec[nxt_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_q   <= 1'b1;
            grant_q <= '0;
            kind_q  <= OWN_CPU;
            ptr_q   <= '0;
            mix_q   <= 1'b0;
        end else begin
            mix_q <= mix_now;
            if (unit_done) begin
                cpu_q   <= nxt_cpu;
                grant_q <= nxt_vec;
                kind_q  <= nxt_kind;
                if (rr_mode && !nxt_cpu)
                    ptr_q <= IW'(ring_next(int'(nxt_idx), NCH));
            end
        end
    end

    AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
        $onehot({cpu_q, grant_q})); // R2

    AST_HOLD_MIDUNIT: assert property (@(posedge clk) disable iff (rst)
        !unit_done |=> $stable({cpu_q, grant_q})); // R2

    AST_BURST_LOCKOUT: assert property (@(posedge clk) disable iff (rst)
        unit_done && any_burst && !(rr_mode && any_steal) |=> !cpu_q); // R5

    AST_IDLE_TO_CPU: assert property (@(posedge clk) disable iff (rst)
        unit_done && !any_burst && !any_steal |=> cpu_q); // R8

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rr_mode,
    input  logic           unit_done,
    input  logic [NCH-1:0] ch_req,
    input  logic [NCH-1:0] ch_is_burst,
    output logic [NCH-1:0] ch_grant,
    output logic           cpu_grant,
    output logic           mix_err
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    logic [NCH-1:0] burst_req, steal_req;
    logic           any_burst, any_steal, mix_now;
    logic           b_found, s_found, a_found;
    logic [IW-1:0]  b_idx, s_idx, a_idx;
    logic [IW-1:0]  ptr_q, ptr_eff;

    assign ptr_eff = rr_mode ? ptr_q : '0;

    arb_mode_split #(.NCH(NCH)) u_split (
        .rr_mode     (rr_mode),
        .ch_req      (ch_req),
        .ch_is_burst (ch_is_burst),
        .burst_req   (burst_req),
        .steal_req   (steal_req),
        .any_burst   (any_burst),
        .any_steal   (any_steal),
        .mix_now     (mix_now)
    );

    arb_ring_pick #(.N(NCH), .IW(IW)) u_pick_burst (
        .vec(burst_req), .start(ptr_eff), .found(b_found), .idx(b_idx));
    arb_ring_pick #(.N(NCH), .IW(IW)) u_pick_steal (
        .vec(steal_req), .start(ptr_eff), .found(s_found), .idx(s_idx));
    arb_ring_pick #(.N(NCH), .IW(IW)) u_pick_any (
        .vec(ch_req),    .start(ptr_eff), .found(a_found), .idx(a_idx));

    arb_owner_core #(.NCH(NCH), .IW(IW)) u_core (
        .clk         (clk),
        .rst         (rst),
        .rr_mode     (rr_mode),
        .unit_done   (unit_done),
        .ch_is_burst (ch_is_burst),
        .any_burst   (any_burst),
        .any_steal   (any_steal),
        .mix_now     (mix_now),
        .b_found     (b_found),
        .b_idx       (b_idx),
        .s_found     (s_found),
        .s_idx       (s_idx),
        .a_found     (a_found),
        .a_idx       (a_idx),
        .ptr_q       (ptr_q),
        .grant_q     (ch_grant),
        .cpu_q       (cpu_grant),
        .mix_q       (mix_err)
    );

    AST_GRANT_WAS_REQ: assert property (@(posedge clk) disable iff (rst)
        unit_done |=> cpu_grant || ((ch_grant & $past(ch_req)) != '0)); // R3

    AST_RESET_CPU: assert property (@(posedge clk)
        rst |=> cpu_grant && (ch_grant == '0) && !mix_err); // R1

endmodule

// File: tb/test_dma_bus_arbiter.sv
`timescale 1ns/1ps
module test_dma_bus_arbiter;
    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           rr_mode = 1'b0;
    logic           unit_done = 1'b0;
    logic [NCH-1:0] ch_req = '0;
    logic [NCH-1:0] ch_is_burst = '0;
    logic [NCH-1:0] ch_grant;
    logic           cpu_grant;
    logic           mix_err;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic           cpu;
        logic [NCH-1:0] ch;
        string          tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    dma_bus_arbiter #(.NCH(NCH)) i_dma_bus_arbiter (
        .clk(clk), .rst(rst), .rr_mode(rr_mode), .unit_done(unit_done),
        .ch_req(ch_req), .ch_is_burst(ch_is_burst),
        .ch_grant(ch_grant), .cpu_grant(cpu_grant), .mix_err(mix_err)
    );

    // Monitor: after each boundary edge, pop and compare
    always @(posedge clk) begin : mon
        logic d;
        d = unit_done;
        #1;
        if (d && !rst) begin
            if (sb.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL %s: grant with no expected item", "R2");
            end else begin
                exp_t e;
                e = sb.pop_front();
                n_cmp++;
                if (e.cpu !== cpu_grant || e.ch !== ch_grant) begin
                    n_bad++;
                    $display("FAIL %s: actual cpu=%0b ch=%b expected cpu=%0b ch=%b",
                             e.tag, cpu_grant, ch_grant, e.cpu, e.ch);
                end
            end
        end
    end

    // Driver: one boundary, expected owner (-1 = CPU)
    task automatic step(input int ech, input string tag);
        exp_t e;
        @(negedge clk);
        e.cpu = (ech < 0);
        e.ch  = (ech < 0) ? '0 : (NCH'(1) << ech);
        e.tag = tag;
        sb.push_back(e);
        unit_done = 1'b1;
        @(negedge clk);
        unit_done = 1'b0;
    endtask

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    initial begin : watchdog
        #(4 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        cmp("R1 cpu", 32'(cpu_grant), 1);
        cmp("R1 ch", 32'(ch_grant), 0);
        cmp("R1 err", 32'(mix_err), 0);
        rst = 1'b0;
        @(negedge clk);
        cmp("R1 after release", 32'({cpu_grant, ch_grant}), 32'h10);

        step(-1, "R8 idle");

        // R2: no boundary, no change
        ch_req = 4'b0010; ch_is_burst = 4'b0010;
        repeat (3) @(negedge clk);
        cmp("R2 hold", 32'({cpu_grant, ch_grant}), 32'h10);

        // R5 / R3: ch1 burst, then ch0 burst preempts
        step(1, "R5 ch1 burst");
        step(1, "R5 lockout");
        ch_req = 4'b0011; ch_is_burst = 4'b0011;
        step(0, "R3 preempt");
        step(0, "R3 keep");
        ch_req = 4'b0010;
        step(1, "R3 resume");
        ch_req = 4'b0000;
        step(-1, "R8 done");

        // R6: two burst channels
        ch_req = 4'b1100; ch_is_burst = 4'b1100;
        step(2, "R6 lowest idx");
        step(2, "R6 again");
        ch_req = 4'b0000;
        step(-1, "R8");

        // R4: ch0 steal interrupts ch1 burst
        ch_req = 4'b0010; ch_is_burst = 4'b0010;
        step(1, "R4 burst");
        ch_req = 4'b0011;
        step(0, "R4 steal first");
        step(1, "R4 burst turn");
        step(0, "R4 steal turn");
        step(1, "R4 burst turn2");
        ch_req = 4'b0010;
        step(1, "R4 burst alone");
        // lower-priority steal waits behind burst
        ch_req = 4'b0110; ch_is_burst = 4'b0010;
        step(1, "R5 low steal waits");
        step(1, "R5 low steal waits2");
        ch_req = 4'b0000;
        step(-1, "R8");

        // R7: steal only, alternate with CPU
        ch_req = 4'b0100; ch_is_burst = 4'b0000;
        step(2, "R7 steal");
        step(-1, "R7 cpu slot");
        step(2, "R7 steal again");
        ch_req = 4'b0000;
        step(-1, "R8");

        // R9: round-robin, all burst
        rr_mode = 1'b1;
        ch_req = 4'b0111; ch_is_burst = 4'b0111;
        step(0, "R9 first");
        step(1, "R9 rot1");
        step(2, "R9 rot2");
        step(0, "R9 wrap");
        step(1, "R9 rot3");
        ch_req = 4'b0000;
        step(-1, "R8 rr");

        // R11: round-robin, steal only (pointer at 2)
        ch_req = 4'b1001; ch_is_burst = 4'b0000;
        step(3, "R11 ch3");
        step(-1, "R11 cpu");
        step(0, "R11 ch0");
        step(-1, "R11 cpu2");
        step(3, "R11 ch3 again");
        ch_req = 4'b0000;
        step(-1, "R11 idle");

        // R10: round-robin with mixed modes (pointer at 0)
        ch_req = 4'b0011; ch_is_burst = 4'b0001;
        @(negedge clk);
        cmp("R10 err set", 32'(mix_err), 1);
        step(0, "R10 ch0");
        step(-1, "R10 cpu");
        step(1, "R10 ch1");
        step(-1, "R10 cpu2");
        rr_mode = 1'b0;
        @(negedge clk);
        cmp("R10 err clear", 32'(mix_err), 0);
        step(0, "R10 fixed ch0");
        ch_req = 4'b0000;
        step(-1, "R8 end");

        repeat (2) @(negedge clk);
        if (sb.size() != 0) begin
            n_bad++;
            $display("FAIL R2: actual %0d pending expected 0", sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule